// File: doc/BRIEF.md
# Scan Row Delay-Capture Controller

This block is one row of scan cells together with a small row header. The header holds a two-bit row code and a freeze register. A global mode pair chooses between three operations. In functional operation every cell loads its row input. In scan shift the header bits and the cells form one serial path. In delay-capture operation the row code decides which cells stay functional and which ones flush.

A flushing cell copies its left neighbour on every clock tick. A path-under-test signal enters at an insertion cell and advances one cell per tick while the capture strobe is high. The falling strobe clears the freeze register, which stops all flushing. The frozen pattern records how the signal behaved over time, including glitches, and is scanned out afterwards.

The insertion point is set by the scan data itself. A run of ones is loaded from the left, and the cell after the first zero becomes the insertion point. A fully flushing row takes its left input from the row's scan input, so the propagation path continues from the previous row in the chain.

Top module: `scan_row_delay_cap`

## Requirements
- R1: While reset is asserted, all cells, both header bits and the freeze register are cleared, so `func_q` and `scan_out` read 0.
- R2: With the mode pair at {a,b}=00 (functional), every cell loads `func_d` on each clock edge.
- R3: With {a,b}=01, each clock edge shifts the serial path `scan_in` → header bit1 → header bit0 → cell0 … cell N-1, and `scan_out` is cell N-1. With {a,b}=10, nothing changes.
- R4: During capture ({a,b}=11) the header bits hold their value. Scanning out afterwards returns the loaded code, with bit0 at `scan_out` after N shifts and bit1 after N+1 shifts.
- R5: Row code 00 keeps every cell functional in capture mode. Each cell loads `func_d` on every tick and none flushes.
- R6: Row code 01 makes every cell flush. Cell0 takes `scan_in` and cell i takes cell i-1 on each flush tick.
- R7: Row code 11 splits the row. Cells up to and including the first zero in the loaded pattern stay functional and load `func_d`. The next cell takes `put_in`, and the cells to its right copy their left neighbour.
- R8: Row code 10 makes cell0 the insertion point. Every cell flushes, and cell0 takes `put_in`.
- R9: Row code 11 with a pattern of all ones has no insertion point, and every cell stays functional.
- R10: The per-cell functional/flush split is sampled from the cell contents on every clock edge outside capture mode and is held during capture. Functional cells that reload inside capture do not move the insertion point.
- R11: A flush tick happens only while `cap_strobe` is high and the freeze register is set. A falling `cap_strobe` clears the freeze register, and later strobe pulses flush nothing.
- R12: `set_n` low at a clock edge sets the freeze register to 1, which enables flushing again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| gm_a | input | 1 | Global mode pair, first line |
| gm_b | input | 1 | Global mode pair, second line |
| cap_strobe | input | 1 | Capture strobe; high lets the row flush, its fall freezes the row |
| set_n | input | 1 | Synchronous active-low preload of the freeze register |
| func_d | input | N_CELLS | Functional inputs, one per cell |
| put_in | input | 1 | Selected path-under-test output to inject |
| scan_in | input | 1 | Serial scan input, also the flush source of a fully flushing row |
| func_q | output | N_CELLS | Cell contents |
| scan_out | output | 1 | Serial output from the last cell, feeding the next row |

## Verification
Each row code is run with its own loaded pattern.

- Code 11 uses a short run of ones, and `put_in` toggles during the flush. This shows that the signal advances exactly one cell per tick and that a glitch is kept in the snapshot. The functional cells reload values that would shift the insertion point if the split were not held.
- Code 10 uses all-zero contents, which separates insertion at cell0 from insertion after a zero.
- Code 11 with all ones shows that a row with no insertion point is fully functional.
- Code 01 draws its flush input from `scan_in`. The run then adds a strobe pulse after the freeze and a fresh preload, which separates level-gated flushing from flushing driven by the freeze register.

// File: rtl/scan_row_pkg.sv
package scan_row_pkg;
  typedef enum logic [1:0] {
    ROW_FUNC       = 2'b00,
    ROW_FLUSH      = 2'b01,
    ROW_SPLIT_LEFT = 2'b10,
    ROW_SPLIT      = 2'b11
  } row_code_e;
endpackage

// File: rtl/scan_row_hdr.sv
module scan_row_hdr
  import scan_row_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      shift_en,
  input  logic      set_n,
  input  logic      cap_strobe,
  input  logic      scan_in,
  output row_code_e code,
  output logic      hdr_so,
  output logic      freeze_q,
  output logic      strobe_q
);
  logic bit1_q, bit0_q;

  // header bits only move on a shift step, so capture cannot disturb them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit1_q <= 1'b0;
      bit0_q <= 1'b0;
    end else if (shift_en) begin
      bit1_q <= scan_in;
      bit0_q <= bit1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= cap_strobe;
      if (!set_n)
        freeze_q <= 1'b1;
      else if (strobe_q && !cap_strobe)
        freeze_q <= 1'b0;
    end
  end

  assign code   = row_code_e'({bit1_q, bit0_q});
  assign hdr_so = bit0_q;
endmodule

// File: rtl/scan_row_mode.sv
module scan_row_mode
  import scan_row_pkg::*;
#(
  parameter int N_CELLS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  row_code_e          code,
  input  logic [N_CELLS-1:0] cell_q,
  output logic [N_CELLS-1:0] func_m,
  output logic [N_CELLS-1:0] ins_m
);
  logic [N_CELLS-1:0] live_c;
  logic [N_CELLS-1:0] live_q;

  // propagating mode bit: stays one across the leading run of ones
  generate
    for (genvar i = 0; i < N_CELLS; i++) begin : g_live
      if (i == 0) begin : g_head
        assign live_c[i] = (code == ROW_SPLIT);
        assign ins_m[i]  = !live_q[i] && (code == ROW_SPLIT_LEFT);
      end else begin : g_body
        assign live_c[i] = live_c[i-1] & cell_q[i-1];
        assign ins_m[i]  = !live_q[i] && live_q[i-1] && (code == ROW_SPLIT);
      end
      assign func_m[i] = (code == ROW_FUNC) || live_q[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      live_q <= '0;
    else if (!capture)
      live_q <= live_c;
  end
endmodule

// File: rtl/scan_row_cell.sv
module scan_row_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic func_en,
  input  logic capture,
  input  logic flush_en,
  input  logic is_func,
  input  logic is_ins,
  input  logic func_d,
  input  logic scan_left,
  input  logic flush_left,
  input  logic put_in,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= 1'b0;
    else if (shift_en)
      q <= scan_left;
    else if (func_en)
      q <= func_d;
    else if (capture) begin
      if (is_func)
        q <= func_d;
      else if (flush_en)
        q <= is_ins ? put_in : flush_left;
    end
  end
endmodule

// File: rtl/scan_row_delay_cap.sv
module scan_row_delay_cap
  import scan_row_pkg::*;
#(
  parameter int N_CELLS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gm_a,
  input  logic               gm_b,
  input  logic               cap_strobe,
  input  logic               set_n,
  input  logic [N_CELLS-1:0] func_d,
  input  logic               put_in,
  input  logic               scan_in,
  output logic [N_CELLS-1:0] func_q,
  output logic               scan_out
);
  logic      shift_en, func_en, capture, flush_en;
  row_code_e code;
  logic      hdr_so, freeze_q, strobe_q;
  logic [N_CELLS-1:0] func_m, ins_m, cell_q;

  assign shift_en = !gm_a && gm_b;
  assign func_en  = !gm_a && !gm_b;
  assign capture  = gm_a && gm_b;
  assign flush_en = capture && cap_strobe && freeze_q;

  scan_row_hdr hdr_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .set_n(set_n),
    .cap_strobe(cap_strobe), .scan_in(scan_in), .code(code),
    .hdr_so(hdr_so), .freeze_q(freeze_q), .strobe_q(strobe_q)
  );

  scan_row_mode #(.N_CELLS(N_CELLS)) mode_i (
    .clk(clk), .rst_n(rst_n), .capture(capture), .code(code),
    .cell_q(cell_q), .func_m(func_m), .ins_m(ins_m)
  );

  generate
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      logic scan_l, flush_l;
      if (i == 0) begin : g_first
        assign scan_l  = hdr_so;
        assign flush_l = scan_in;
      end else begin : g_rest
        assign scan_l  = cell_q[i-1];
        assign flush_l = cell_q[i-1];
      end
      scan_row_cell cell_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .func_en(func_en),
        .capture(capture), .flush_en(flush_en), .is_func(func_m[i]),
        .is_ins(ins_m[i]), .func_d(func_d[i]), .scan_left(scan_l),
        .flush_left(flush_l), .put_in(put_in), .q(cell_q[i])
      );
    end
  endgenerate

  assign func_q   = cell_q;
  assign scan_out = cell_q[N_CELLS-1];
endmodule

// File: rtl/scan_row_chk.sv
module scan_row_chk #(
  parameter int N_CELLS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gm_a,
  input logic               gm_b,
  input logic               cap_strobe,
  input logic [N_CELLS-1:0] func_d,
  input logic               scan_in,
  input logic [N_CELLS-1:0] func_q,
  input logic               scan_out,
  input logic [1:0]         hdr_code,
  input logic               freeze_q
);
  // R2
  func_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gm_a && !gm_b) |=> (func_q == $past(func_d)));
  // R3
  shift_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gm_a && gm_b) |=> (scan_out == $past(func_q[N_CELLS-2])));
  // R3
  a_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gm_a && !gm_b) |=> $stable(func_q));
  // R4
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gm_a && gm_b) |=> $stable(hdr_code));
  // R5
  row_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gm_a && gm_b && hdr_code == 2'b00) |=> (func_q == $past(func_d)));
  // R6
  flush_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gm_a && gm_b && hdr_code == 2'b01 && cap_strobe && freeze_q)
      |=> (func_q[0] == $past(scan_in)));
  // R11
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gm_a && gm_b && hdr_code == 2'b01 && !freeze_q) |=> $stable(func_q));
endmodule

bind scan_row_delay_cap scan_row_chk #(.N_CELLS(N_CELLS)) chk_i (
  .clk(clk), .rst_n(rst_n), .gm_a(gm_a), .gm_b(gm_b),
  .cap_strobe(cap_strobe), .func_d(func_d), .scan_in(scan_in),
  .func_q(func_q), .scan_out(scan_out), .hdr_code(code),
  .freeze_q(freeze_q)
);

// File: tb/scan_row_delay_cap_tb_top.sv
`timescale 1ns/1ps
module scan_row_delay_cap_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gm_a = 1'b0, gm_b = 1'b0;
  logic cap_strobe = 1'b0, set_n = 1'b1, put_in = 1'b0, scan_in = 1'b0;
  logic [N-1:0] func_d = '0;
  logic [N-1:0] func_q;
  logic scan_out;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scan_row_delay_cap #(.N_CELLS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .gm_a(gm_a), .gm_b(gm_b),
    .cap_strobe(cap_strobe), .set_n(set_n), .func_d(func_d),
    .put_in(put_in), .scan_in(scan_in), .func_q(func_q), .scan_out(scan_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_gm(input logic [1:0] m);
    {gm_a, gm_b} = m;
  endtask

  task automatic load_row(input logic [1:0] code, input logic [N-1:0] cells);
    set_gm(2'b01);
    for (int i = N-1; i >= 0; i--) begin
      scan_in = cells[i];
      tick();
    end
    scan_in = code[0]; tick();
    scan_in = code[1]; tick();
    scan_in = 1'b0;
    set_gm(2'b10);
    tick();
    chk("R3 load", func_q, cells);
    tick();
    chk("R3 a-only hold", func_q, cells);
  endtask

  task automatic arm();
    set_gm(2'b11);
    cap_strobe = 1'b0;
    set_n = 1'b0;
    tick();
    set_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 cells", func_q, '0);
    chk("R1 scan_out", {{(N-1){1'b0}}, scan_out}, '0);
  endtask

  task automatic t_functional();
    set_gm(2'b00);
    func_d = 8'hA5; tick();
    chk("R2 first", func_q, 8'hA5);
    func_d = 8'h3C; tick();
    chk("R2 second", func_q, 8'h3C);
  endtask

  task automatic t_split();
    load_row(2'b11, 8'b0000_0011);
    func_d = 8'hF5;
    arm();
    put_in = 1'b1; cap_strobe = 1'b1;
    tick(); tick();
    chk("R7 R10 two ticks", func_q, 8'h1D);
    put_in = 1'b0;
    tick();
    chk("R7 glitch kept", func_q, 8'h35);
    cap_strobe = 1'b0; put_in = 1'b1;
    tick();
    chk("R11 fall freezes", func_q, 8'h35);
    cap_strobe = 1'b1;
    tick(); tick();
    chk("R11 no flush after freeze", func_q, 8'h35);
    cap_strobe = 1'b0;
  endtask

  task automatic t_split_left();
    load_row(2'b10, 8'h00);
    func_d = 8'hFF;
    arm();
    put_in = 1'b1; cap_strobe = 1'b1;
    tick(); tick(); tick();
    chk("R8 insert at cell0", func_q, 8'h07);
    cap_strobe = 1'b0; tick();
  endtask

  task automatic t_all_ones();
    load_row(2'b11, 8'hFF);
    func_d = 8'h5A;
    arm();
    put_in = 1'b0; cap_strobe = 1'b1;
    tick(); tick();
    chk("R9 no insertion", func_q, 8'h5A);
    cap_strobe = 1'b0; tick();
  endtask

  task automatic t_row_func();
    load_row(2'b00, 8'h00);
    func_d = 8'hC3;
    arm();
    put_in = 1'b1; cap_strobe = 1'b1;
    tick();
    chk("R5 loads func_d", func_q, 8'hC3);
    func_d = 8'h3C; tick();
    chk("R5 follows func_d", func_q, 8'h3C);
    cap_strobe = 1'b0; tick();
  endtask

  task automatic t_full_flush();
    load_row(2'b01, 8'h00);
    func_d = 8'hFF;
    arm();
    scan_in = 1'b1; cap_strobe = 1'b1;
    tick(); tick(); tick();
    chk("R6 flush from scan_in", func_q, 8'h07);
    cap_strobe = 1'b0; tick();
    cap_strobe = 1'b1; tick(); tick();
    chk("R11 frozen row", func_q, 8'h07);
    cap_strobe = 1'b0; set_n = 1'b0; tick();
    set_n = 1'b1; cap_strobe = 1'b1; tick();
    chk("R12 preload re-enables flush", func_q, 8'h0F);
    cap_strobe = 1'b0; scan_in = 1'b0; tick();
    set_gm(2'b01);
    for (int k = 0; k < N; k++) tick();
    chk("R4 header bit0 kept", {{(N-1){1'b0}}, scan_out}, 8'h01);
    tick();
    chk("R4 header bit1 kept", {{(N-1){1'b0}}, scan_out}, 8'h00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_functional();
    t_split();
    t_split_left();
    t_all_ones();
    t_row_func();
    t_full_flush();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule